// File: doc/BRIEF.md
# Two-Slot Elastic Pipeline Stage

This block is one stage of a flow-controlled pipeline. It passes fixed-width flits from an upstream port to a downstream port and uses a valid/ready handshake on each side. A flit moves across a port on a rising clock edge only when valid and ready are both high on that port. The stage holds up to two flits, so it can keep a full stream moving even though its upstream ready comes from a register. Stages chained back to back form a channel that acts as a distributed FIFO when the far end stalls.

A three-state controller tracks the fill level: empty, one flit held, or two flits held. The state is stored in two bits with encodings 00, 01 and 11. Upstream ready is the inverse of the upper state bit. Downstream valid is the lower state bit. Neither output has a combinational path from any input. Two data registers hold the flits. The head register always drives the output. The spare register catches a flit that arrives while the head is stalled, and it moves into the head when the head leaves.

Top module: `twin_slot_stage`

## Requirements
- R1: While rst_n is low, and after its release with no input activity, dn_valid is 0 and up_ready is 1.
- R2: Flits leave in the order they were accepted (up_valid and up_ready high at a rising edge), with none lost or duplicated.
- R3: up_ready goes low only when two flits are held. When one flit is held, a flit is accepted and dn_ready is low, up_ready is 0 after that edge.
- R4: dn_valid is 1 whenever at least one flit is held, and is 0 after the only flit leaves with no new flit accepted.
- R5: While dn_valid is 1 and dn_ready is 0, dn_valid and dn_data do not change at the next edge.
- R6: With up_valid and dn_ready held high, the stage accepts and delivers one flit every cycle. A flit accepted at one edge is on dn_data after that edge.
- R7: up_ready and dn_valid change only at clock edges. A change of dn_ready or up_valid between edges leaves them unchanged.
- R8: A flit offered while up_ready is 0 is not captured and never appears at dn_data.
- R9: With one flit held, a simultaneous accept and departure leaves one flit held. up_ready stays 1 and the new flit is presented after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_data | input | WIDTH | Flit offered by the upstream side |
| up_valid | input | 1 | Upstream flit is valid |
| up_ready | output | 1 | Stage has at least one free slot |
| dn_data | output | WIDTH | Oldest held flit |
| dn_valid | output | 1 | At least one flit is held |
| dn_ready | input | 1 | Downstream can take the presented flit |

## Verification
The bench first fills a single stage against a stalled downstream. It checks that ready drops only on the second flit and that a flit offered while full is dropped. A design that counted slots wrongly would either overwrite the stalled head or accept a third flit that later shows up in the stream. Toggling dn_ready between edges exposes any combinational path to up_ready. A simultaneous accept and departure with one flit held catches controllers that wrongly step to the full state or leave a bubble. A chain of stages under random source and sink stalls is checked against a scoreboard queue. That stage reports any reordering, duplication or loss, and any change of output data during a stall.

// File: rtl/twin_slot_pkg.sv
package twin_slot_pkg;

  localparam int unsigned TS_DEFAULT_WIDTH = 32;

  // Fill-level encoding: bit 1 = "no free slot", bit 0 = "flit presented".
  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_ONE   = 2'b01,
    ST_TWO   = 2'b11
  } slot_state_e;

endpackage

// File: rtl/twin_slot_ctrl.sv
module twin_slot_ctrl
  import twin_slot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_valid,
  input  logic dn_ready,
  output logic up_ready,
  output logic dn_valid,
  output logic head_load,
  output logic head_from_spare,
  output logic spare_load
);

  slot_state_e state_q, state_d;
  logic        accept, depart;

  // Handshake outputs come straight from the state bits.
  assign up_ready = ~state_q[1];
  assign dn_valid = state_q[0];
  assign accept   = up_valid & up_ready;
  assign depart   = dn_valid & dn_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_EMPTY: if (up_valid)             state_d = ST_ONE;
      ST_ONE: begin
        if (up_valid && !dn_ready)        state_d = ST_TWO;
        else if (!up_valid && dn_ready)   state_d = ST_EMPTY;
      end
      ST_TWO:   if (dn_ready)             state_d = ST_ONE;
      default:                            state_d = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_EMPTY;
    else        state_q <= state_d;
  end

  // Datapath enables: head takes new data when empty or when replacing a
  // departing flit; spare catches a flit behind a stalled head.
  always_comb begin
    head_load       = 1'b0;
    head_from_spare = 1'b0;
    spare_load      = 1'b0;
    unique case (state_q)
      ST_EMPTY: head_load = accept;
      ST_ONE: begin
        head_load  = accept & depart;
        spare_load = accept & ~depart;
      end
      ST_TWO: begin
        head_load       = depart;
        head_from_spare = 1'b1;
      end
      default: ;
    endcase
  end

  // R3: accepting behind a stalled single flit fills the stage
  a_r3_fill_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && dn_valid && !dn_ready) |=> !up_ready);

  // R4: no free slot means a flit is being presented
  a_r4_full_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !up_ready |-> dn_valid);

  // R4: nothing held and nothing arriving stays empty
  a_r4_idle_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_valid && !up_valid) |=> !dn_valid);

  // R9: pass-through with one flit keeps one flit
  a_r9_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && dn_valid && dn_ready && up_ready) |=> (up_ready && dn_valid));

  // R3: a full stage with downstream taking a flit frees a slot
  a_r3_drain_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_ready && dn_ready) |=> (up_ready && dn_valid));

endmodule

// File: rtl/twin_slot_store.sv
module twin_slot_store #(
  parameter int unsigned WIDTH = twin_slot_pkg::TS_DEFAULT_WIDTH
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] up_data,
  input  logic             head_load,
  input  logic             head_from_spare,
  input  logic             spare_load,
  output logic [WIDTH-1:0] dn_data
);

  logic [WIDTH-1:0] head_q, spare_q, head_d;

  assign head_d  = head_from_spare ? spare_q : up_data;
  assign dn_data = head_q;

  always_ff @(posedge clk) begin
    if (head_load) head_q <= head_d;
  end

  always_ff @(posedge clk) begin
    if (spare_load) spare_q <= up_data;
  end

endmodule

// File: rtl/twin_slot_stage.sv
module twin_slot_stage #(
  parameter int unsigned WIDTH = twin_slot_pkg::TS_DEFAULT_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] up_data,
  input  logic             up_valid,
  output logic             up_ready,
  output logic [WIDTH-1:0] dn_data,
  output logic             dn_valid,
  input  logic             dn_ready
);

  logic head_load, head_from_spare, spare_load;

  twin_slot_ctrl ctrl_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .up_valid        (up_valid),
    .dn_ready        (dn_ready),
    .up_ready        (up_ready),
    .dn_valid        (dn_valid),
    .head_load       (head_load),
    .head_from_spare (head_from_spare),
    .spare_load      (spare_load)
  );

  twin_slot_store #(.WIDTH(WIDTH)) store_i (
    .clk             (clk),
    .up_data         (up_data),
    .head_load       (head_load),
    .head_from_spare (head_from_spare),
    .spare_load      (spare_load),
    .dn_data         (dn_data)
  );

  // R5: a stalled flit is held unchanged
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

endmodule

// File: tb/twin_slot_stage_tb_top.sv
module twin_slot_stage_tb_top;

  localparam int unsigned W = 16;
  localparam int unsigned N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int unsigned tests = 0;
  int unsigned fails = 0;
  bit          done  = 1'b0;

  // single stage for directed checks
  logic [W-1:0] d_up_data = '0;
  logic         d_up_valid = 1'b0;
  logic         d_up_ready;
  logic [W-1:0] d_dn_data;
  logic         d_dn_valid;
  logic         d_dn_ready = 1'b0;

  twin_slot_stage #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .up_data(d_up_data), .up_valid(d_up_valid), .up_ready(d_up_ready),
    .dn_data(d_dn_data), .dn_valid(d_dn_valid), .dn_ready(d_dn_ready)
  );

  // chain of stages for random stress
  logic [W-1:0] src_data = '0;
  logic         src_valid = 1'b0;
  logic         sink_ready = 1'b0;
  logic [W-1:0] c_data  [0:N];
  logic         c_valid [0:N];
  logic         c_ready [0:N];

  assign c_data[0]  = src_data;
  assign c_valid[0] = src_valid;
  assign c_ready[N] = sink_ready;

  for (genvar g = 0; g < N; g++) begin : chain_g
    twin_slot_stage #(.WIDTH(W)) stg_i (
      .clk(clk), .rst_n(rst_n),
      .up_data(c_data[g]), .up_valid(c_valid[g]), .up_ready(c_ready[g]),
      .dn_data(c_data[g+1]), .dn_valid(c_valid[g+1]), .dn_ready(c_ready[g+1])
    );
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard state
  logic [W-1:0] exp_q [$];
  logic [W-1:0] next_val  = 16'h0001;
  bit           prev_stall = 1'b0;
  logic [W-1:0] prev_data  = '0;

  // one chain cycle: inputs are set at the negedge, then the handshakes that
  // will complete at the next posedge are recorded (outputs are registered).
  task automatic chain_cycle(input bit rnd);
    @(negedge clk);
    if (rnd) begin
      src_valid  = ($urandom % 4) != 0;
      sink_ready = ($urandom % 3) != 0;
    end else begin
      src_valid  = 1'b0;
      sink_ready = 1'b1;
    end
    src_data = next_val;
    if (prev_stall)   // R5 across the whole chain
      chk(c_valid[N] && (c_data[N] == prev_data), "R5 chain hold",
          {15'd0, c_valid[N], c_data[N]}, {16'd1, prev_data});
    if (c_valid[N] && sink_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 chain unexpected flit", {16'd0, c_data[N]}, 32'd0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(c_data[N] == e, "R2 chain order", {16'd0, c_data[N]}, {16'd0, e});
      end
    end
    prev_stall = c_valid[N] && !sink_ready;
    prev_data  = c_data[N];
    if (src_valid && c_ready[0]) begin
      exp_q.push_back(src_data);
      next_val = next_val + 16'd1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(d_dn_valid == 1'b0, "R1 valid in reset", {31'd0, d_dn_valid}, 32'd0);
    chk(d_up_ready == 1'b1, "R1 ready in reset", {31'd0, d_up_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(d_dn_valid == 1'b0 && d_up_ready == 1'b1, "R1 after release",
        {30'd0, d_dn_valid, d_up_ready}, 32'd1);

    // offer A, downstream stalled
    d_up_valid = 1'b1; d_up_data = 16'hA0A0; d_dn_ready = 1'b0;
    @(negedge clk);
    chk(d_dn_valid == 1'b1, "R4 valid with one flit", {31'd0, d_dn_valid}, 32'd1);
    chk(d_dn_data == 16'hA0A0, "R2 first flit", {16'd0, d_dn_data}, 32'hA0A0);
    chk(d_up_ready == 1'b1, "R3 ready with one flit", {31'd0, d_up_ready}, 32'd1);

    // offer B, still stalled -> full
    d_up_data = 16'hB1B1;
    @(negedge clk);
    chk(d_up_ready == 1'b0, "R3 ready low when full", {31'd0, d_up_ready}, 32'd0);
    chk(d_dn_data == 16'hA0A0, "R5 head held", {16'd0, d_dn_data}, 32'hA0A0);

    // offer C while full: must be ignored
    d_up_data = 16'hC2C2;
    @(negedge clk);
    chk(d_up_ready == 1'b0 && d_dn_data == 16'hA0A0, "R8 full ignores offer",
        {15'd0, d_up_ready, d_dn_data}, 32'h0000A0A0);

    // R7: mid-cycle changes of dn_ready / up_valid do not reach the outputs
    d_dn_ready = 1'b1; d_up_valid = 1'b0;
    #1;
    chk(d_up_ready == 1'b0, "R7 ready registered", {31'd0, d_up_ready}, 32'd0);
    chk(d_dn_valid == 1'b1, "R7 valid registered", {31'd0, d_dn_valid}, 32'd1);

    @(negedge clk);   // A leaves, B moves to head
    chk(d_dn_data == 16'hB1B1, "R2 second flit in order", {16'd0, d_dn_data}, 32'hB1B1);
    chk(d_up_ready == 1'b1, "R3 slot freed", {31'd0, d_up_ready}, 32'd1);

    // one held, accept D while B leaves
    d_up_valid = 1'b1; d_up_data = 16'hD3D3; d_dn_ready = 1'b1;
    @(negedge clk);
    chk(d_dn_data == 16'hD3D3, "R8 dropped flit absent / R9 new head",
        {16'd0, d_dn_data}, 32'hD3D3);
    chk(d_up_ready == 1'b1 && d_dn_valid == 1'b1, "R9 stays one-held",
        {30'd0, d_up_ready, d_dn_valid}, 32'd3);

    // drain D
    d_up_valid = 1'b0;
    @(negedge clk);
    chk(d_dn_valid == 1'b0, "R4 empty after drain", {31'd0, d_dn_valid}, 32'd0);

    // R6: full-rate stream
    for (int k = 0; k < 8; k++) begin
      if (k > 0)
        chk(d_dn_valid && d_up_ready && d_dn_data == W'(16'h0100 + k - 1),
            "R6 stream", {15'd0, d_dn_valid, d_dn_data}, 32'h1_0000 + 32'h0100 + k - 1);
      d_up_valid = 1'b1; d_up_data = W'(16'h0100 + k); d_dn_ready = 1'b1;
      @(negedge clk);
    end
    chk(d_dn_valid && d_dn_data == 16'h0107, "R6 stream last",
        {15'd0, d_dn_valid, d_dn_data}, 32'h0001_0107);
    d_up_valid = 1'b0;

    // random stress on the chain
    for (int i = 0; i < 3000; i++) chain_cycle(1'b1);
    for (int i = 0; i < 4 * N + 4; i++) chain_cycle(1'b0);
    chk(exp_q.size() == 0, "R2 chain no loss", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule